// File: doc/BRIEF.md
# DES Round-Step Datapath for a Processor Extension

This block is a DES execution unit that sits beside a processor's integer pipeline. Software drives it with four single-cycle operations. Three of them move 32-bit words between the processor and the unit's internal state. Every such move passes through the matching DES bit permutation on the way. The fourth operation advances the cipher by one Feistel round. It uses only the state already held inside the unit.

The unit keeps three state registers: a left data half, a right data half and a 56-bit key held as two 28-bit halves. Writing a data word places its bits through the initial permutation. Writing a key word places its bits through the key-selection permutation and drops the parity bits. Reading a data word applies the final permutation to the swapped halves. To cipher one block, software loads the key and the block, issues sixteen round operations and then reads the result.

In encryption mode the key halves rotate left before each subkey is taken, so after sixteen rounds they are back at their loaded value. In decryption mode they rotate right after the subkey is taken. Triple-DES runs as three passes. Software reads the result of each pass and writes it back as the block for the next pass, under a newly loaded key.

Top module: `des_unit`

## Requirements
- R1: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high, and low otherwise.
- R2: Operation code 2'b01 writes a data word. `req_half`=1 supplies block bits 63:32 (the first bits of the block) and `req_half`=0 supplies bits 31:0. The state receives the initial permutation of the block, and each write changes only the state bits that its half feeds, so the two halves may be written in either order or rewritten.
- R3: Operation code 2'b11 writes a key word. `req_half` selects the half as in R2. The key passes through the key-selection permutation, bit 0 of every key byte (parity) has no effect, and the round counter returns to 0.
- R4: Operation code 2'b00 performs one round: L takes R, and R takes L xor F(R, subkey). Every operation other than a read returns `rsp_data` = 0.
- R5: Operation code 2'b10 returns half of the final permutation of {R, L}, with `req_half` selecting the half as in R2. A read leaves the state unchanged.
- R6: With `req_decrypt`=0, a key write, a block write and sixteen rounds produce the standard DES ciphertext of the block.
- R7: With `req_decrypt`=1, a key write, a ciphertext write and sixteen rounds produce the plaintext.
- R8: After sixteen rounds in either mode the key halves and the round counter are back at their loaded values, so the next block under the same key needs no key reload.
- R9: After reset the state holds zero and the round counter is 0, so sixteen encryption rounds give the DES ciphertext of the all-zero block under the all-zero key. After reset `rsp_valid` and `rsp_data` are 0.
- R10: While `req_valid` is low, the opcode, operand and mode inputs have no effect on the state.
- R11: Three passes (encrypt, decrypt, encrypt) with a key reload and a block write-back between the passes give the Triple-DES result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 2 | 00 round, 01 data write, 10 data read, 11 key write |
| req_half | input | 1 | 1 selects block/key bits 63:32, 0 selects bits 31:0 |
| req_decrypt | input | 1 | Round direction: 1 decrypt, 0 encrypt |
| req_operand | input | 32 | Source word for write operations |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_data | output | 32 | Read result; zero for other operations |

## Verification
The assertions assume that `req_op`, `req_half` and `req_decrypt` carry known values whenever `req_valid` is high. They also assume that the mode input stays constant over the sixteen rounds of one block, and that both key halves are written before any rounds run. The bench drives every request from a single task that sets all request fields together. It holds the mode fixed within each round burst and always loads keys as a high-then-low pair. Its idle-cycle stimulus puts deliberately hostile values on the opcode and operand, but only while `req_valid` is low.

// File: rtl/des_pkg.sv
// Package: des_pkg
// Shared widths, operation codes and the DES permutation and substitution
// functions. Every permutation is a fixed bit reorder once the loops unroll.
// Assumes DES bit numbering: bit 1 is the most significant bit of a vector.
package des_pkg;

    localparam int BLOCK_W    = 64;
    localparam int WORD_W     = 32;
    localparam int KHALF_W    = 28;
    localparam int KEYST_W    = 2 * KHALF_W;
    localparam int SUBKEY_W   = 48;
    localparam int ROUNDS     = 16;
    localparam int CNT_W      = $clog2(ROUNDS);
    localparam int NUM_SBOX   = 8;

    typedef enum logic [1:0] {
        OP_ROUND   = 2'b00,
        OP_DATA_WR = 2'b01,
        OP_DATA_RD = 2'b10,
        OP_KEY_WR  = 2'b11
    } des_op_e;

    localparam int PC1_T [KEYST_W] = '{
        57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

    localparam int PC2_T [SUBKEY_W] = '{
        14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

    localparam int P_T [WORD_W] = '{
        16,  7, 20, 21, 29, 12, 28, 17,  1, 15, 23, 26,  5, 18, 31, 10,
         2,  8, 24, 14, 32, 27,  3,  9, 19, 13, 30,  6, 22, 11,  4, 25};

    // Each entry: one S-box, 64 nibbles, row-major (row*16 + column).
    localparam logic [255:0] SBOX_T [NUM_SBOX] = '{
        256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
        256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
        256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
        256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
        256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
        256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
        256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
        256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B};

    // Source bit (1-based) of initial-permutation output position pos (0-based).
    function automatic int ip_src(input int pos);
        int row;
        int col;
        row = pos / 8;
        col = pos % 8;
        return ((row < 4) ? (58 + 2 * row) : (57 + 2 * (row - 4))) - 8 * col;
    endfunction

    function automatic logic [BLOCK_W-1:0] ip_perm(input logic [BLOCK_W-1:0] x);
        logic [BLOCK_W-1:0] y;
        y = '0;
        for (int i = 0; i < BLOCK_W; i++) y[BLOCK_W-1-i] = x[BLOCK_W-ip_src(i)];
        return y;
    endfunction

    function automatic logic [BLOCK_W-1:0] fp_perm(input logic [BLOCK_W-1:0] x);
        logic [BLOCK_W-1:0] y;
        y = '0;
        for (int i = 0; i < BLOCK_W; i++) y[BLOCK_W-ip_src(i)] = x[BLOCK_W-1-i];
        return y;
    endfunction

    function automatic logic [KEYST_W-1:0] pc1_perm(input logic [BLOCK_W-1:0] k);
        logic [KEYST_W-1:0] y;
        y = '0;
        for (int i = 0; i < KEYST_W; i++) y[KEYST_W-1-i] = k[BLOCK_W-PC1_T[i]];
        return y;
    endfunction

    function automatic logic [SUBKEY_W-1:0] pc2_perm(input logic [KEYST_W-1:0] cd);
        logic [SUBKEY_W-1:0] y;
        y = '0;
        for (int i = 0; i < SUBKEY_W; i++) y[SUBKEY_W-1-i] = cd[KEYST_W-PC2_T[i]];
        return y;
    endfunction

    // Expansion: six-bit groups overlapping their neighbours by one bit, wrapping.
    function automatic logic [SUBKEY_W-1:0] e_expand(input logic [WORD_W-1:0] r);
        logic [SUBKEY_W-1:0] y;
        int src;
        y = '0;
        for (int j = 0; j < SUBKEY_W; j++) begin
            src = 4 * (j / 6) + (j % 6);
            if (src == 0) src = WORD_W;
            if (src == WORD_W + 1) src = 1;
            y[SUBKEY_W-1-j] = r[WORD_W-src];
        end
        return y;
    endfunction

    function automatic logic [WORD_W-1:0] p_perm(input logic [WORD_W-1:0] x);
        logic [WORD_W-1:0] y;
        y = '0;
        for (int i = 0; i < WORD_W; i++) y[WORD_W-1-i] = x[WORD_W-P_T[i]];
        return y;
    endfunction

    // Outer bits choose the row, inner four bits the column.
    function automatic logic [3:0] sbox_look(input int box, input logic [5:0] six);
        logic [5:0] idx;
        idx = {six[5], six[0], six[4:1]};
        return SBOX_T[box][255 - 4 * int'(idx) -: 4];
    endfunction

    // Shift schedule: one position in rounds 0, 1, 8 and 15, two elsewhere.
    function automatic int shift_of(input logic [CNT_W-1:0] n);
        return (n == 0 || n == 1 || n == 8 || n == CNT_W'(ROUNDS - 1)) ? 1 : 2;
    endfunction

    function automatic logic [KHALF_W-1:0] rotl28(input logic [KHALF_W-1:0] v, input int n);
        logic [2*KHALF_W-1:0] t;
        t = {v, v} << n;
        return t[2*KHALF_W-1:KHALF_W];
    endfunction

    function automatic logic [KHALF_W-1:0] rotr28(input logic [KHALF_W-1:0] v, input int n);
        logic [2*KHALF_W-1:0] t;
        t = {v, v} >> n;
        return t[KHALF_W-1:0];
    endfunction

    // Put a word into the selected half of a 64-bit vector.
    function automatic logic [BLOCK_W-1:0] place_word(input logic hi, input logic [WORD_W-1:0] w);
        return hi ? {w, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, w};
    endfunction

endpackage

// File: rtl/des_feistel.sv
// Module: des_feistel
// Combinational round function F(R, K) = P(S(E(R) xor K)).
// Assumes: nothing beyond valid inputs; purely combinational.
module des_feistel
    import des_pkg::*;
(
    input  logic [WORD_W-1:0]   half_in,
    input  logic [SUBKEY_W-1:0] subkey,
    output logic [WORD_W-1:0]   f_out
);

    logic [SUBKEY_W-1:0] mixed;
    logic [WORD_W-1:0]   subst;

    // Expand the half block and mix in the subkey.
    assign mixed = e_expand(half_in) ^ subkey;

    // One substitution box per six-bit group.
    for (genvar g = 0; g < NUM_SBOX; g++) begin : g_sbox
        logic [5:0] six;
        assign six = mixed[SUBKEY_W-1-6*g -: 6];
        assign subst[WORD_W-1-4*g -: 4] = sbox_look(g, six);
    end

    // Final wire reorder of the substituted word.
    assign f_out = p_perm(subst);

endmodule

// File: rtl/des_keypath.sv
// Module: des_keypath
// Holds the 56-bit key state (two 28-bit halves) and the round counter,
// and presents the subkey for the current round.
// Assumes: both key halves are written before rounds start, and the mode
// input stays constant for the 16 rounds of one block.
module des_keypath
    import des_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                key_we,
    input  logic                key_hi,
    input  logic [WORD_W-1:0]   key_word,
    input  logic                round_go,
    input  logic                decrypt,
    output logic [SUBKEY_W-1:0] subkey
);

    logic [KEYST_W-1:0] cd_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [KHALF_W-1:0] c_enc, d_enc, c_dec, d_dec;
    logic [KEYST_W-1:0] key_mask, key_bits;

    // Rotated key halves for both directions of the current round.
    always_comb begin
        c_enc = rotl28(cd_q[KEYST_W-1:KHALF_W], shift_of(cnt_q));
        d_enc = rotl28(cd_q[KHALF_W-1:0], shift_of(cnt_q));
        c_dec = rotr28(cd_q[KEYST_W-1:KHALF_W], shift_of(CNT_W'(ROUNDS - 1) - cnt_q));
        d_dec = rotr28(cd_q[KHALF_W-1:0], shift_of(CNT_W'(ROUNDS - 1) - cnt_q));
    end

    // Encryption uses the halves after rotation; decryption uses them before.
    assign subkey = decrypt ? pc2_perm(cd_q) : pc2_perm({c_enc, d_enc});

    // Key-state bits fed by the written half, and their new values.
    assign key_mask = pc1_perm(place_word(key_hi, {WORD_W{1'b1}}));
    assign key_bits = pc1_perm(place_word(key_hi, key_word));

    // Key state and round counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cd_q  <= '0;
            cnt_q <= '0;
        end else if (key_we) begin
            cd_q  <= (cd_q & ~key_mask) | key_bits;
            cnt_q <= '0;
        end else if (round_go) begin
            cd_q  <= decrypt ? {c_dec, d_dec} : {c_enc, d_enc};
            cnt_q <= (cnt_q == CNT_W'(ROUNDS - 1)) ? '0 : cnt_q + 1'b1;
        end
    end

    // A key write always restarts the round schedule.
    assert_key_restarts_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        key_we |=> (cnt_q == '0));

    // The last round of a block returns the counter to the first round.
    assert_count_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (round_go && !key_we && cnt_q == CNT_W'(ROUNDS - 1)) |=> (cnt_q == '0));

    // Without a key write or round the key state holds.
    assert_key_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_we && !round_go) |=> $stable(cd_q));

endmodule

// File: rtl/des_unit.sv
// Module: des_unit
// DES execution unit with four single-cycle operations: round step,
// permuted data write, permuted data read and permuted key write.
// Assumes: request fields are known whenever req_valid is high.
module des_unit
    import des_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              req_half,
    input  logic              req_decrypt,
    input  logic [WORD_W-1:0] req_operand,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data
);

    des_op_e             op;
    logic                do_round, do_dwr, do_drd, do_kwr;
    logic [WORD_W-1:0]   left_q, right_q;
    logic [SUBKEY_W-1:0] subkey;
    logic [WORD_W-1:0]   f_val;
    logic [BLOCK_W-1:0]  dat_mask, dat_bits, out_blk;

    // Decode the request.
    always_comb begin
        op       = des_op_e'(req_op);
        do_round = req_valid && (op == OP_ROUND);
        do_dwr   = req_valid && (op == OP_DATA_WR);
        do_drd   = req_valid && (op == OP_DATA_RD);
        do_kwr   = req_valid && (op == OP_KEY_WR);
    end

    des_keypath u_keypath (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_we   (do_kwr),
        .key_hi   (req_half),
        .key_word (req_operand),
        .round_go (do_round),
        .decrypt  (req_decrypt),
        .subkey   (subkey)
    );

    des_feistel u_feistel (
        .half_in (right_q),
        .subkey  (subkey),
        .f_out   (f_val)
    );

    // State bits fed by the written half after the initial permutation.
    assign dat_mask = ip_perm(place_word(req_half, {WORD_W{1'b1}}));
    assign dat_bits = ip_perm(place_word(req_half, req_operand));

    // Output view: halves swapped, then the final permutation.
    assign out_blk = fp_perm({right_q, left_q});

    // Data half registers: permuted write or one Feistel round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
        end else if (do_dwr) begin
            {left_q, right_q} <= ({left_q, right_q} & ~dat_mask) | dat_bits;
        end else if (do_round) begin
            left_q  <= right_q;
            right_q <= left_q ^ f_val;
        end
    end

    // Registered response, one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_data  <= do_drd ? (req_half ? out_blk[BLOCK_W-1:WORD_W] : out_blk[WORD_W-1:0])
                                : '0;
        end
    end

    assert_rsp_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_rsp_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_nonread_returns_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op != OP_DATA_RD) |=> (rsp_data == '0));

    assert_read_keeps_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        do_drd |=> ($stable(left_q) && $stable(right_q)));

    assert_idle_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(left_q) && $stable(right_q)));

endmodule

// File: tb/des_unit_test.sv
module des_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_op;
    logic        req_half;
    logic        req_decrypt;
    logic [31:0] req_operand;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    always #4 clk = ~clk;   // 125 MHz

    des_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_half    (req_half),
        .req_decrypt (req_decrypt),
        .req_operand (req_operand),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data)
    );

    // {key, plaintext, ciphertext}
    localparam logic [191:0] VEC [4] = '{
        {64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 64'h85E813540F0AB405},
        {64'h0E329232EA6D0D73, 64'h8787878787878787, 64'h0000000000000000},
        {64'h0000000000000000, 64'h0000000000000000, 64'h8CA64DE9C1B123A7},
        {64'h0123456789ABCDEF, 64'h4E6F772069732074, 64'h3FA40E8A984D4815}};

    localparam logic [1:0] C_ROUND = 2'b00;
    localparam logic [1:0] C_DWR   = 2'b01;
    localparam logic [1:0] C_DRD   = 2'b10;
    localparam logic [1:0] C_KWR   = 2'b11;

    int          n_checks = 0;
    int          n_fails  = 0;
    logic        last_v;
    logic [31:0] last_d;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One request; called at a negedge, returns at the next negedge.
    task automatic issue(input logic [1:0] op, input logic hi, input logic dec, input logic [31:0] w);
        req_valid   = 1'b1;
        req_op      = op;
        req_half    = hi;
        req_decrypt = dec;
        req_operand = w;
        @(negedge clk);
        last_v    = rsp_valid;
        last_d    = rsp_data;
        req_valid = 1'b0;
    endtask

    task automatic load_key(input logic [63:0] k);
        issue(C_KWR, 1'b1, 1'b0, k[63:32]);
        issue(C_KWR, 1'b0, 1'b0, k[31:0]);
    endtask

    task automatic load_block(input logic [63:0] b);
        issue(C_DWR, 1'b1, 1'b0, b[63:32]);
        issue(C_DWR, 1'b0, 1'b0, b[31:0]);
    endtask

    task automatic run_rounds(input int n, input logic dec);
        for (int i = 0; i < n; i++) issue(C_ROUND, 1'b0, dec, 32'h0);
    endtask

    task automatic read_block(output logic [63:0] v);
        issue(C_DRD, 1'b1, 1'b0, 32'h0);
        v[63:32] = last_d;
        issue(C_DRD, 1'b0, 1'b0, 32'h0);
        v[31:0] = last_d;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [63:0] got;
        logic [63:0] mid_a;
        logic [63:0] mid_b;
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_op = 2'b00;
        req_half = 1'b0;
        req_decrypt = 1'b0;
        req_operand = 32'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state of the response and the cipher state
        check("R9 rsp_valid after reset", {63'h0, rsp_valid}, 64'h0);
        check("R9 rsp_data after reset", {32'h0, rsp_data}, 64'h0);
        run_rounds(16, 1'b0);
        read_block(got);
        check("R9 zero state ciphers zero block", got, 64'h8CA64DE9C1B123A7);

        // R6 / R7: table walk, encrypt then decrypt each vector
        for (int v = 0; v < 4; v++) begin
            load_key(VEC[v][191:128]);
            load_block(VEC[v][127:64]);
            run_rounds(16, 1'b0);
            read_block(got);
            check($sformatf("R6 encrypt vector %0d", v), got, VEC[v][63:0]);
            load_key(VEC[v][191:128]);
            load_block(VEC[v][63:0]);
            run_rounds(16, 1'b1);
            read_block(got);
            check($sformatf("R7 decrypt vector %0d", v), got, VEC[v][127:64]);
        end

        // R1 / R4: response timing and zero data for a non-read
        issue(C_KWR, 1'b1, 1'b0, 32'h13345779);
        check("R1 rsp_valid after request", {63'h0, last_v}, 64'h1);
        check("R4 rsp_data zero after key write", {32'h0, last_d}, 64'h0);
        @(negedge clk);
        check("R1 rsp_valid after idle", {63'h0, rsp_valid}, 64'h0);

        // R8: second block under the same key without reload, both modes
        load_key(VEC[0][191:128]);
        load_block(VEC[0][127:64]);
        run_rounds(16, 1'b0);
        load_block(VEC[0][127:64]);
        run_rounds(16, 1'b0);
        read_block(got);
        check("R8 second encrypt without reload", got, VEC[0][63:0]);
        load_block(VEC[0][63:0]);
        run_rounds(16, 1'b1);
        load_block(VEC[0][63:0]);
        run_rounds(16, 1'b1);
        read_block(got);
        check("R8 second decrypt without reload", got, VEC[0][127:64]);

        // R2: half writes in reverse order and with an overwritten half
        load_key(VEC[0][191:128]);
        issue(C_DWR, 1'b0, 1'b0, 32'hFFFFFFFF);
        issue(C_DWR, 1'b1, 1'b0, 32'h01234567);
        issue(C_DWR, 1'b0, 1'b0, 32'h89ABCDEF);
        run_rounds(16, 1'b0);
        read_block(got);
        check("R2 low-first with rewrite", got, VEC[0][63:0]);

        // R3: parity bits ignored
        load_key(64'h123556789ABDDEF0);
        load_block(VEC[0][127:64]);
        run_rounds(16, 1'b0);
        read_block(got);
        check("R3 parity bits ignored", got, VEC[0][63:0]);

        // R3: a key write mid-block restarts the schedule
        load_key(VEC[3][191:128]);
        load_block(VEC[3][127:64]);
        run_rounds(5, 1'b0);
        load_key(VEC[0][191:128]);
        load_block(VEC[0][127:64]);
        run_rounds(16, 1'b0);
        read_block(got);
        check("R3 key write resets round counter", got, VEC[0][63:0]);

        // R10 / R5: hostile idle inputs and repeated reads mid-block
        load_key(VEC[0][191:128]);
        load_block(VEC[0][127:64]);
        run_rounds(8, 1'b0);
        for (int i = 0; i < 3; i++) begin
            req_op = C_KWR;
            req_half = i[0];
            req_decrypt = 1'b1;
            req_operand = 32'hA5A5A5A5;
            @(negedge clk);
            check("R10 no response while idle", {63'h0, rsp_valid}, 64'h0);
        end
        req_op = C_DWR;
        @(negedge clk);
        read_block(mid_a);
        read_block(mid_b);
        check("R5 repeated read gives same value", mid_b, mid_a);
        run_rounds(8, 1'b0);
        read_block(got);
        check("R10 R5 state untouched by idle and reads", got, VEC[0][63:0]);

        // R11: three passes with key reloads and write-back
        load_key(VEC[0][191:128]);
        load_block(64'h8787878787878787);
        run_rounds(16, 1'b0);
        read_block(mid_a);
        load_key(VEC[0][191:128]);
        load_block(mid_a);
        run_rounds(16, 1'b1);
        read_block(mid_b);
        check("R11 second pass", mid_b, 64'h8787878787878787);
        load_key(VEC[1][191:128]);
        load_block(mid_b);
        run_rounds(16, 1'b0);
        read_block(got);
        check("R11 third pass result", got, 64'h0000000000000000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule